// File: doc/BRIEF.md
# CRT Vertical Scan Timing and Retrace Flagging

This block tracks the current scanline of a CRT-style display controller. Each horizontal sync tick advances a 10-bit line counter by one, and the counter returns to line 0 when it reaches the programmed vertical total. A vertical retrace window opens at a programmed start line and closes a short, programmable number of lines later. Two single-cycle strobes mark the edges of that window. The first tells downstream fetch logic to capture the display start address and line pitch. The second tells it to apply the captured values to the next frame. Software can therefore rewrite panning and start-address registers at any point inside retrace without producing a torn frame.

The block also forms the bits for the input status read. These are the vertical and horizontal sync levels, each with its own inversion control, and a display-disabled bit. A read of that status produces a one-cycle pulse that resets the attribute controller's index/data toggle. A small guard decides whether a register write may go ahead. It blocks writes to the eight lowest timing registers while the protect bit of the retrace-end register is set.

All pins are plain control and status signals. Nothing streams through the block, so no valid/ready handshake is involved.

Top module: `crt_vtiming`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `line_no` is 0, and `latch_stb`, `update_stb`, `vretrace` and `acff_clr` are all 0.
- R2: A clock with `hsync_tick` high moves `line_no` to its next value, visible after that edge. A clock with `hsync_tick` low leaves `line_no` unchanged.
- R3: The vertical total is `{vtotal_ovf[1], vtotal_ovf[0], vtotal_lo}`. Bit 9 comes from `vtotal_ovf[1]` and bit 8 from `vtotal_ovf[0]`. Lines count from 0 to total-1, and a tick at line total-1 returns the counter to 0.
- R4: Retrace start is `{vrs_ovf[1], vrs_ovf[0], vrs_lo}`. Retrace end is start plus `vre_reg[3:0]`, computed without wrap. `vretrace` is 1 exactly when start <= `line_no` <= end. It follows a tick in the same cycle as `line_no`, and it follows a register change one cycle later.
- R5: `latch_stb` is high for the one cycle after a tick that moves `line_no` onto the retrace start line. It is low in every other cycle.
- R6: `update_stb` is high for the one cycle after a tick that moves `line_no` onto the retrace end line. When the length field is 0, it is high in the same cycle as `latch_stb`.
- R7: `stat_vsync` equals `vretrace` XOR `vsync_inv`. `stat_hsync` equals `hsync_active` XOR `hsync_inv`.
- R8: `stat_dd` is 1 whenever `vretrace` or `hsync_active` is 1. It ignores both inversion controls.
- R9: `acff_clr` is high for exactly the cycle after each cycle in which `status_rd` is high.
- R10: `wr_allow` equals `wr_en`, except that it is 0 when `vre_reg[7]` is 1 and `wr_idx` is below 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_tick | input | 1 | One-cycle pulse per horizontal sync |
| hsync_active | input | 1 | Horizontal sync level, true polarity |
| vtotal_lo | input | 8 | Vertical total bits 7:0 |
| vtotal_ovf | input | 2 | Vertical total bits 9 (index 1) and 8 (index 0) |
| vrs_lo | input | 8 | Retrace start bits 7:0 |
| vrs_ovf | input | 2 | Retrace start bits 9 (index 1) and 8 (index 0) |
| vre_reg | input | 8 | Retrace-end register: [3:0] length, [7] write protect |
| vsync_inv | input | 1 | Invert reported vertical sync |
| hsync_inv | input | 1 | Invert reported horizontal sync |
| status_rd | input | 1 | Status port read strobe |
| wr_en | input | 1 | Register write request |
| wr_idx | input | 5 | Index of the register being written |
| line_no | output | 10 | Current scanline |
| vretrace | output | 1 | Inside vertical retrace window |
| latch_stb | output | 1 | Capture display start parameters |
| update_stb | output | 1 | Apply captured parameters |
| stat_vsync | output | 1 | Status bit: vertical sync after polarity |
| stat_hsync | output | 1 | Status bit: horizontal sync after polarity |
| stat_dd | output | 1 | Status bit: display disabled |
| acff_clr | output | 1 | Clear pulse for attribute index/data toggle |
| wr_allow | output | 1 | Register write permitted |

## Verification
The hardest state to reach is a retrace window that sits above line 255. Reaching it needs both overflow bits of the total and of the start to be decoded correctly, and it needs the counter to run through more than 256 ticks before the strobes can be seen. The bench programs a total of 260 with the window on lines 258 and 259. It then drives a full frame of back-to-back ticks and compares every line against its own model, so the strobes and the wrap from line 259 to 0 are all checked. It also runs a zero-length window, where both strobes land on the same line.

// File: rtl/crtv_pkg.sv
package crtv_pkg;
  localparam int OVF_W = 2;

  // Join a low byte with its two overflow bits (index 1 -> MSB).
  function automatic logic [9:0] join_line(input logic [7:0] lo, input logic [1:0] ovf);
    return {ovf[1], ovf[0], lo};
  endfunction

  typedef struct packed {
    logic latch;
    logic update;
  } edge_stb_t;
endpackage

// File: rtl/crtv_line_counter.sv
module crtv_line_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] total,
  output logic [W-1:0] line_q,
  output logic [W-1:0] line_nx
);
  logic [W:0] inc;

  always_comb begin
    inc = {1'b0, line_q} + {{W{1'b0}}, 1'b1};
    if (!tick)
      line_nx = line_q;
    else if (inc >= {1'b0, total})
      line_nx = '0;
    else
      line_nx = inc[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_nx;
  end

  // R2: no tick, no movement
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> line_q == $past(line_q));

  // R3: counter never lands at or above the total in force at the tick
  assert_below_total_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && total != '0) |=> line_q < $past(total));
endmodule

// File: rtl/crtv_retrace_window.sv
module crtv_retrace_window #(
  parameter int W     = 10,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [W-1:0]     line_nx,
  input  logic [W-1:0]     start,
  input  logic [LEN_W-1:0] len,
  output logic             vret_q,
  output crtv_pkg::edge_stb_t stb_q
);
  import crtv_pkg::*;

  logic [W:0] end_ext;
  logic [W:0] line_ext;
  logic       in_win;
  edge_stb_t  stb_d;

  always_comb begin
    end_ext      = {1'b0, start} + {{(W+1-LEN_W){1'b0}}, len};
    line_ext     = {1'b0, line_nx};
    in_win       = (line_ext >= {1'b0, start}) && (line_ext <= end_ext);
    stb_d.latch  = tick && (line_nx == start);
    stb_d.update = tick && (line_ext == end_ext);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vret_q <= 1'b0;
      stb_q  <= '0;
    end else begin
      vret_q <= in_win;
      stb_q  <= stb_d;
    end
  end

  // R5: a capture strobe only occurs inside the retrace window
  assert_latch_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q.latch |-> vret_q);

  // R6: an apply strobe only occurs inside the retrace window
  assert_update_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q.update |-> vret_q);

  // R5: capture strobe is a single-cycle pulse when the line keeps moving
  assert_latch_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q.latch && tick && line_nx != $past(line_nx)) |=> !stb_q.latch);
endmodule

// File: rtl/crtv_status_port.sv
module crtv_status_port #(
  parameter int NSYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSYNC-1:0] sync_raw,
  input  logic [NSYNC-1:0] sync_inv,
  input  logic             rd,
  output logic [NSYNC-1:0] sync_rep,
  output logic             dd,
  output logic             clr_q
);
  for (genvar g = 0; g < NSYNC; g++) begin : g_pol
    assign sync_rep[g] = sync_raw[g] ^ sync_inv[g];
  end

  assign dd = |sync_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= rd;
  end

  // R9: each read produces the clear pulse on the next cycle
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> clr_q);

  // R9: no clear pulse without a read in the previous cycle
  assert_clear_needs_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && $past(rst_n)) |-> $past(rd));
endmodule

// File: rtl/crt_vtiming.sv
module crt_vtiming #(
  parameter int LO_W     = 8,
  parameter int LEN_W    = 4,
  parameter int IDX_W    = 5,
  parameter int PROT_CNT = 8,
  parameter int PROT_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_tick,
  input  logic              hsync_active,
  input  logic [LO_W-1:0]   vtotal_lo,
  input  logic [1:0]        vtotal_ovf,
  input  logic [LO_W-1:0]   vrs_lo,
  input  logic [1:0]        vrs_ovf,
  input  logic [7:0]        vre_reg,
  input  logic              vsync_inv,
  input  logic              hsync_inv,
  input  logic              status_rd,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  output logic [LO_W+1:0]   line_no,
  output logic              vretrace,
  output logic              latch_stb,
  output logic              update_stb,
  output logic              stat_vsync,
  output logic              stat_hsync,
  output logic              stat_dd,
  output logic              acff_clr,
  output logic              wr_allow
);
  import crtv_pkg::*;

  localparam int LINE_W = LO_W + OVF_W;

  logic [LINE_W-1:0] total_w, start_w, line_nx;
  edge_stb_t         stb;
  logic [1:0]        rep;
  logic              protect;

  assign total_w = join_line(vtotal_lo, vtotal_ovf);
  assign start_w = join_line(vrs_lo, vrs_ovf);

  crtv_line_counter #(.W(LINE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (hsync_tick),
    .total   (total_w),
    .line_q  (line_no),
    .line_nx (line_nx)
  );

  crtv_retrace_window #(.W(LINE_W), .LEN_W(LEN_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (hsync_tick),
    .line_nx (line_nx),
    .start   (start_w),
    .len     (vre_reg[LEN_W-1:0]),
    .vret_q  (vretrace),
    .stb_q   (stb)
  );

  assign latch_stb  = stb.latch;
  assign update_stb = stb.update;

  crtv_status_port #(.NSYNC(2)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_raw ({vretrace, hsync_active}),
    .sync_inv ({vsync_inv, hsync_inv}),
    .rd       (status_rd),
    .sync_rep (rep),
    .dd       (stat_dd),
    .clr_q    (acff_clr)
  );

  assign stat_vsync = rep[1];
  assign stat_hsync = rep[0];

  assign protect  = vre_reg[PROT_BIT];
  assign wr_allow = wr_en && !(protect && (int'(wr_idx) < PROT_CNT));

  // R10: a protected low-index write never gets through
  assert_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vre_reg[PROT_BIT] && int'(wr_idx) < PROT_CNT) |-> !wr_allow);

  // R8: display-disabled follows vertical retrace regardless of inversion
  assert_dd_vret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vretrace |-> stat_dd);
endmodule

// File: tb/crt_vtiming_test.sv
`timescale 1ns/1ps
module crt_vtiming_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_tick = 1'b0, hsync_active = 1'b0;
  logic [7:0] vtotal_lo = 8'd20, vrs_lo = 8'd10, vre_reg = 8'd3;
  logic [1:0] vtotal_ovf = 2'b00, vrs_ovf = 2'b00;
  logic vsync_inv = 1'b0, hsync_inv = 1'b0, status_rd = 1'b0, wr_en = 1'b0;
  logic [4:0] wr_idx = '0;
  logic [9:0] line_no;
  logic vretrace, latch_stb, update_stb, stat_vsync, stat_hsync, stat_dd, acff_clr, wr_allow;

  int n_chk = 0, n_bad = 0;
  int exp_line = 0;
  bit done = 0;

  always #4 clk = ~clk;

  crt_vtiming uut (
    .clk(clk), .rst_n(rst_n), .hsync_tick(hsync_tick), .hsync_active(hsync_active),
    .vtotal_lo(vtotal_lo), .vtotal_ovf(vtotal_ovf), .vrs_lo(vrs_lo), .vrs_ovf(vrs_ovf),
    .vre_reg(vre_reg), .vsync_inv(vsync_inv), .hsync_inv(hsync_inv),
    .status_rd(status_rd), .wr_en(wr_en), .wr_idx(wr_idx),
    .line_no(line_no), .vretrace(vretrace), .latch_stb(latch_stb),
    .update_stb(update_stb), .stat_vsync(stat_vsync), .stat_hsync(stat_hsync),
    .stat_dd(stat_dd), .acff_clr(acff_clr), .wr_allow(wr_allow)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cfg_total();
    return {vtotal_ovf, vtotal_lo};
  endfunction
  function automatic int cfg_start();
    return {vrs_ovf, vrs_lo};
  endfunction
  function automatic int cfg_end();
    return cfg_start() + int'(vre_reg[3:0]);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 line in reset", line_no, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    exp_line = 0;
  endtask

  // One tick, then compare line, window and strobes with the model.
  task automatic tick_chk(input string tag);
    int s, e;
    hsync_tick = 1'b1;
    @(negedge clk);
    hsync_tick = 1'b0;
    exp_line = (exp_line + 1 >= cfg_total()) ? 0 : exp_line + 1;
    s = cfg_start(); e = cfg_end();
    check({tag, " R2/R3 line"}, line_no, exp_line);
    check({tag, " R4 vretrace"}, vretrace, int'(exp_line >= s && exp_line <= e));
    check({tag, " R5 latch_stb"}, latch_stb, int'(exp_line == s));
    check({tag, " R6 update_stb"}, update_stb, int'(exp_line == e));
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 line after reset", line_no, 0);
    check("R1 latch_stb", latch_stb, 0);
    check("R1 update_stb", update_stb, 0);
    check("R1 vretrace", vretrace, 0);
    check("R1 acff_clr", acff_clr, 0);
  endtask

  task automatic t_count_hold();
    do_reset();
    for (int i = 0; i < 4; i++) tick_chk("count");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 hold without tick", line_no, exp_line);
    end
  endtask

  task automatic t_window_basic();
    vtotal_lo = 8'd20; vtotal_ovf = 2'b00; vrs_lo = 8'd10; vrs_ovf = 2'b00; vre_reg = 8'd3;
    do_reset();
    for (int i = 0; i < 45; i++) tick_chk("basic");
  endtask

  task automatic t_zero_len();
    vtotal_lo = 8'd12; vrs_lo = 8'd5; vre_reg = 8'd0;
    do_reset();
    for (int i = 0; i < 14; i++) tick_chk("len0");
  endtask

  task automatic t_high_bits();
    vtotal_lo = 8'd4; vtotal_ovf = 2'b01;   // total 260
    vrs_lo = 8'd2; vrs_ovf = 2'b01;         // start 258
    vre_reg = 8'd1;                          // end 259
    do_reset();
    for (int i = 0; i < 265; i++) tick_chk("high");
    vtotal_ovf = 2'b00; vrs_ovf = 2'b00;
  endtask

  task automatic t_polarity_dd();
    vtotal_lo = 8'd20; vrs_lo = 8'd2; vre_reg = 8'd2;
    do_reset();
    tick_chk("pol"); tick_chk("pol");       // line 2: inside window
    hsync_active = 1'b0; vsync_inv = 1'b0; hsync_inv = 1'b1;
    #1;
    check("R7 vsync normal", stat_vsync, 1);
    check("R7 hsync inverted", stat_hsync, 1);
    check("R8 dd from vretrace", stat_dd, 1);
    vsync_inv = 1'b1; #1;
    check("R7 vsync inverted", stat_vsync, 0);
    check("R8 dd ignores inversion", stat_dd, 1);
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick_chk("pol"); // line 5: outside
    check("R7 vsync inverted outside", stat_vsync, 1);
    check("R8 dd low outside", stat_dd, 0);
    hsync_active = 1'b1; hsync_inv = 1'b0; #1;
    check("R7 hsync normal", stat_hsync, 1);
    check("R8 dd from hsync", stat_dd, 1);
    hsync_active = 1'b0; vsync_inv = 1'b0;
  endtask

  task automatic t_status_read();
    @(negedge clk);
    check("R9 idle", acff_clr, 0);
    status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    check("R9 pulse", acff_clr, 1);
    @(negedge clk);
    check("R9 pulse ends", acff_clr, 0);
  endtask

  task automatic t_write_guard();
    wr_en = 1'b1; vre_reg = 8'h83; wr_idx = 5'd3; #1;
    check("R10 protected low index", wr_allow, 0);
    wr_idx = 5'd7; #1;
    check("R10 protected index 7", wr_allow, 0);
    wr_idx = 5'd8; #1;
    check("R10 index 8 passes", wr_allow, 1);
    vre_reg = 8'h03; wr_idx = 5'd0; #1;
    check("R10 unprotected", wr_allow, 1);
    wr_en = 1'b0; #1;
    check("R10 no request", wr_allow, 0);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_count_hold();
    t_window_basic();
    t_zero_len();
    t_high_bits();
    t_polarity_dd();
    t_status_read();
    t_write_guard();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule